// File: doc/BRIEF.md
# Page-Load EEPROM Write Controller

This block is a clocked model of the write side of a byte-wide parallel EEPROM. It takes active-low chip-enable, write-enable and output-enable pins, together with an address bus and a data bus, and samples them all in the system clock domain. Each time the write condition holds, the block performs one byte load. It captures the address when the condition starts and the data when the condition ends, and it places the byte into a page-sized staging buffer.

The first accepted byte load opens a page. Further loads to the same page may follow, each beginning within a byte-load window of the previous accepted load. When no new load has started for the full window, the block enters a self-timed programming phase. That phase moves the loaded bytes of the buffer into the storage array. `busy` stays high for the whole phase, and loads seen during the phase are dropped.

The strobe pins are plain control pins and have no valid/ready handshake. The block therefore applies no back-pressure: a load that arrives while `busy` is high, or a load aimed at a different page, is discarded and does not stall anything. A combinational inspection port (`peek_addr` / `peek_data`) returns the committed array contents. The read data path of a real device is not modelled.

Top module: `eeprom_page_writer`

## Requirements
- R1: A byte load takes place only during cycles in which `ce_n`=0, `we_n`=0 and `oe_n`=1 are sampled together. Any other combination (`oe_n` low, `we_n` high or `ce_n` high) never loads a byte, never opens a page and never starts programming.
- R2: The load address is the value of `addr` in the first cycle of the write condition, which is the cycle after the later of the two enable strobes falls. Changes on `addr` later in the same load have no effect.
- R3: The stored data is the value of `din` in the last sampled cycle of the write condition, which is the cycle before the earlier of the two enable strobes rises. Later values on `din` have no effect.
- R4: The page number is `addr[ADDR_W-1:PAGE_W]`, and the offset within the page is `addr[PAGE_W-1:0]`. The first accepted load fixes the page. A later load to a different page in the same operation is ignored, and it does not extend the byte-load window.
- R5: Up to 2^PAGE_W bytes can be gathered in one operation. Loading the same offset twice keeps the last value.
- R6: `busy` rises at the (BLC_CYC+1)-th clock edge after the edge at which the last accepted load started, provided no further accepted load starts in between.
- R7: `busy` stays high for exactly PROG_CYC cycles and then falls. The array takes the new bytes only when `busy` falls, and any load attempted while `busy` is high is ignored.
- R8: Only the offsets loaded during the operation change. The other bytes of that page, and all other pages, keep their previous values.
- R9: After reset, `busy` is 0, no page is open, and every array byte reads 8'hFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all pins are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low; a low level inhibits writes |
| addr | input | ADDR_W | Byte address: page in the high bits, offset in the low PAGE_W bits |
| din | input | DATA_W | Write data |
| busy | output | 1 | High while a programming phase is running |
| peek_addr | input | ADDR_W | Array inspection address |
| peek_data | output | DATA_W | Committed array byte at `peek_addr` (combinational) |

## Verification
The embedded assertions check these properties on every cycle:
- a load that completes while a page is open belongs to that page;
- no load is accepted while `busy` is high;
- programming never starts while a load is still in progress;
- `busy` drops right after the commit.

Properties that involve time, ordering and data content can only be shown by the bench scenarios. These are the exact cycle counts of the timeout and the programming phase, and which `addr`/`din` sample a load actually keeps when the strobes are skewed. They also include the fact that untouched bytes survive, and that inhibited, cross-page and busy-time loads leave the whole array unchanged.

// File: rtl/epw_pkg.sv
package epw_pkg;
  typedef enum logic {
    ST_GATHER = 1'b0,
    ST_PROG   = 1'b1
  } prog_st_t;
endpackage

// File: rtl/epw_strobe_decode.sv
module epw_strobe_decode #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              start_p,
  output logic              end_p,
  output logic [ADDR_W-1:0] ld_addr,
  output logic [DATA_W-1:0] ld_data
);
  logic act_in;
  logic act_q;

  // write condition: both enables low, output enable high
  assign act_in  = ~ce_n & ~we_n & oe_n;
  assign start_p = act_in & ~act_q;
  assign end_p   = ~act_in & act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      ld_addr <= '0;
      ld_data <= '0;
    end else begin
      act_q <= act_in;
      if (start_p) ld_addr <= addr;
      // keeps the last value seen while the condition holds
      if (act_in)  ld_data <= din;
    end
  end
endmodule

// File: rtl/epw_page_stage.sv
module epw_page_stage #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 7,
  localparam int PAGE_N = 1 << PAGE_W,
  localparam int PG_W   = ADDR_W - PAGE_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_p,
  input  logic                     end_p,
  input  logic [PG_W-1:0]          live_page,
  input  logic [ADDR_W-1:0]        ld_addr,
  input  logic [DATA_W-1:0]        ld_data,
  input  logic                     busy,
  input  logic                     commit,
  output logic                     restart,
  output logic                     open_q,
  output logic                     pend_q,
  output logic [PG_W-1:0]          page_q,
  output logic [PAGE_N*DATA_W-1:0] stg_flat,
  output logic [PAGE_N-1:0]        mask_q
);
  logic [DATA_W-1:0] stg_q [PAGE_N];
  logic [PAGE_W-1:0] off;
  logic              accept;

  assign off     = ld_addr[PAGE_W-1:0];
  assign accept  = start_p & ~busy & (~open_q | (live_page == page_q));
  assign restart = accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      pend_q <= 1'b0;
      page_q <= '0;
      mask_q <= '0;
    end else if (commit) begin
      open_q <= 1'b0;
      pend_q <= 1'b0;
      mask_q <= '0;
    end else begin
      if (start_p) begin
        pend_q <= accept;
        if (accept && !open_q) page_q <= live_page;
      end
      if (end_p) begin
        pend_q <= 1'b0;
        if (pend_q) begin
          mask_q[off] <= 1'b1;
          open_q      <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (end_p && pend_q && !commit) stg_q[off] <= ld_data;
  end

  for (genvar g = 0; g < PAGE_N; g++) begin : g_flat
    assign stg_flat[g*DATA_W +: DATA_W] = stg_q[g];
  end

  AST_SAME_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (end_p && pend_q && open_q) |-> (ld_addr[ADDR_W-1:PAGE_W] == page_q)); // R4
  AST_NO_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start_p && busy) |=> !pend_q); // R7
endmodule

// File: rtl/epw_prog_ctrl.sv
module epw_prog_ctrl
  import epw_pkg::*;
#(
  parameter int BLC_CYC  = 25000,
  parameter int PROG_CYC = 1250000,
  localparam int TM_W = $clog2(BLC_CYC + 1),
  localparam int PC_W = $clog2(PROG_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic open_q,
  input  logic pend_q,
  output logic busy,
  output logic commit
);
  prog_st_t        st_q;
  logic [TM_W-1:0] tmr_q;
  logic [PC_W-1:0] pc_q;
  logic            expired;
  logic            last_cyc;

  assign expired  = (tmr_q == TM_W'(BLC_CYC));
  assign last_cyc = (pc_q == PC_W'(PROG_CYC - 1));
  assign busy     = (st_q == ST_PROG);
  assign commit   = busy & last_cyc;

  // byte-load window timer, restarted by every accepted load
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            tmr_q <= '0;
    else if (restart)      tmr_q <= '0;
    else if (!expired)     tmr_q <= tmr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_GATHER;
      pc_q <= '0;
    end else begin
      case (st_q)
        ST_GATHER: if (open_q && !pend_q && expired && !restart) begin
          st_q <= ST_PROG;
          pc_q <= '0;
        end
        ST_PROG: if (last_cyc) st_q <= ST_GATHER;
                 else          pc_q <= pc_q + 1'b1;
        default: st_q <= ST_GATHER;
      endcase
    end
  end

  AST_START_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (open_q && !pend_q)); // R6
  AST_COMMIT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !busy); // R7
endmodule

// File: rtl/epw_array.sv
module epw_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 7,
  localparam int PAGE_N = 1 << PAGE_W,
  localparam int PG_W   = ADDR_W - PAGE_W,
  localparam int ARR_N  = 1 << ADDR_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     commit,
  input  logic [PG_W-1:0]          page_q,
  input  logic [PAGE_N*DATA_W-1:0] stg_flat,
  input  logic [PAGE_N-1:0]        mask_q,
  input  logic [ADDR_W-1:0]        peek_addr,
  output logic [DATA_W-1:0]        peek_data
);
  logic [DATA_W-1:0] mem_q [ARR_N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ARR_N; i++) mem_q[i] <= '1;
    end else if (commit) begin
      for (int j = 0; j < PAGE_N; j++) begin
        if (mask_q[j]) mem_q[{page_q, j[PAGE_W-1:0]}] <= stg_flat[j*DATA_W +: DATA_W];
      end
    end
  end

  assign peek_data = mem_q[peek_addr];
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer #(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 8,
  parameter int PAGE_W   = 7,
  parameter int BLC_CYC  = 25000,
  parameter int PROG_CYC = 1250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              busy,
  input  logic [ADDR_W-1:0] peek_addr,
  output logic [DATA_W-1:0] peek_data
);
  localparam int PAGE_N = 1 << PAGE_W;
  localparam int PG_W   = ADDR_W - PAGE_W;

  logic                     start_p, end_p, restart, open_q, pend_q, commit;
  logic [ADDR_W-1:0]        ld_addr;
  logic [DATA_W-1:0]        ld_data;
  logic [PG_W-1:0]          page_q;
  logic [PAGE_N*DATA_W-1:0] stg_flat;
  logic [PAGE_N-1:0]        mask_q;

  epw_strobe_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dec (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .start_p(start_p), .end_p(end_p),
    .ld_addr(ld_addr), .ld_data(ld_data)
  );

  epw_page_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) i_stage (
    .clk(clk), .rst_n(rst_n), .start_p(start_p), .end_p(end_p),
    .live_page(addr[ADDR_W-1:PAGE_W]), .ld_addr(ld_addr), .ld_data(ld_data),
    .busy(busy), .commit(commit), .restart(restart), .open_q(open_q),
    .pend_q(pend_q), .page_q(page_q), .stg_flat(stg_flat), .mask_q(mask_q)
  );

  epw_prog_ctrl #(.BLC_CYC(BLC_CYC), .PROG_CYC(PROG_CYC)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .restart(restart), .open_q(open_q),
    .pend_q(pend_q), .busy(busy), .commit(commit)
  );

  epw_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) i_arr (
    .clk(clk), .rst_n(rst_n), .commit(commit), .page_q(page_q),
    .stg_flat(stg_flat), .mask_q(mask_q), .peek_addr(peek_addr),
    .peek_data(peek_data)
  );

  AST_LOAD_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (end_p && pend_q) |-> !busy); // R7
  AST_NO_COMMIT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (mask_q != '0)); // R8
endmodule

// File: tb/test_eeprom_page_writer.sv
module test_eeprom_page_writer;
  localparam int AW = 8, DW = 8, PW = 3, BLC = 12, PRG = 30;
  localparam int NB = 1 << AW, PN = 1 << PW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0, peek_addr = '0;
  logic [DW-1:0] din = '0, peek_data;
  logic busy;

  int n_chk = 0, n_bad = 0, cyc = 0, t_last = 0;
  logic [DW-1:0] exp_mem [NB];
  logic [DW-1:0] pdat [PN];
  logic [PN-1:0] pmask = '0;
  logic [AW-PW-1:0] ppage = '0;
  logic pg_open = 1'b0, busy_seen = 1'b0;

  eeprom_page_writer #(.ADDR_W(AW), .DATA_W(DW), .PAGE_W(PW), .BLC_CYC(BLC), .PROG_CYC(PRG))
    i_eeprom_page_writer (.clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
      .addr(addr), .din(din), .busy(busy), .peek_addr(peek_addr), .peek_data(peek_data));

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (busy) busy_seen <= 1'b1;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_raw(logic [AW-1:0] a, logic [DW-1:0] d, bit keep);
    @(negedge clk); ce_n = 0; we_n = 0; addr = a; din = d;
    if (keep) begin
      t_last = cyc + 1;
      if (!pg_open) begin ppage = a[AW-1:PW]; pg_open = 1; end
      pdat[a[PW-1:0]] = d; pmask[a[PW-1:0]] = 1'b1;
    end
    @(negedge clk);
    @(negedge clk); ce_n = 1; we_n = 1; din = ~d;
    @(negedge clk);
  endtask

  task automatic check_all(string req);
    for (int a = 0; a < NB; a++) begin
      peek_addr = AW'(a); #0.1;
      chk(req, int'(peek_data), int'(exp_mem[a]));
    end
  endtask

  task automatic wait_prog(int inject);
    int t;
    t = 0;
    while (!busy && t < 200) begin @(negedge clk); t++; end
    chk("R6 busy rise cycle", cyc, t_last + BLC + 1);
    if (inject >= 0) begin
      peek_addr = AW'(inject); #0.1;
      chk("R7 array old while busy", int'(peek_data), int'(exp_mem[inject]));
      wr_raw(AW'(inject), 8'h3C, 1'b0);
    end
    t = 0;
    while (busy && t < 200) begin @(negedge clk); t++; end
    chk("R7 busy fall cycle", cyc, t_last + BLC + 1 + PRG);
    for (int o = 0; o < PN; o++) if (pmask[o]) exp_mem[{ppage, o[PW-1:0]}] = pdat[o];
    pmask = '0; pg_open = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int a = 0; a < NB; a++) exp_mem[a] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9 busy after reset", int'(busy), 0);
    check_all("R9 erased array");

    // R8 single byte, rest of page untouched; R6/R7 timing
    wr_raw(8'h13, 8'h5A, 1'b1);
    wait_prog(-1);
    check_all("R8 single byte");

    // R5 full-page sweep over every page
    for (int p = 0; p < NB / PN; p++) begin
      for (int o = 0; o < PN; o++) wr_raw(AW'(p * PN + o), DW'((p * PN + o) * 7 + 3), 1'b1);
      wait_prog(-1);
    end
    check_all("R5 full page sweep");

    // R8 partial reverse-order rewrite of odd offsets, R5 last value wins
    for (int p = 0; p < NB / PN; p++) begin
      for (int o = PN - 1; o >= 0; o--)
        if (o % 2 == 1) wr_raw(AW'(p * PN + o), DW'(~(p * PN + o)), 1'b1);
      wr_raw(AW'(p * PN + 1), DW'(p + 8'h40), 1'b1);
      wait_prog(-1);
    end
    check_all("R8 R5 partial rewrite");

    // R4 cross-page load ignored and does not restart timer
    wr_raw(8'h20, 8'h11, 1'b1);
    wr_raw(8'h25, 8'h22, 1'b1);
    wr_raw(8'h48, 8'h33, 1'b0);
    wait_prog(-1);
    check_all("R4 cross page");

    // R7 load during programming ignored
    wr_raw(8'h31, 8'h77, 1'b1);
    wait_prog(8'h32);
    check_all("R7 busy load dropped");
    busy_seen = 0;
    repeat (BLC + PRG + 5) @(negedge clk);
    chk("R7 no second program", int'(busy_seen), 0);

    // R1 inhibit combinations
    busy_seen = 0;
    @(negedge clk); ce_n = 0; we_n = 0; oe_n = 0; addr = 8'h50; din = 8'h99;
    repeat (3) @(negedge clk); ce_n = 1; we_n = 1; oe_n = 1;
    @(negedge clk); ce_n = 1; we_n = 0; addr = 8'h51;
    repeat (3) @(negedge clk); we_n = 1;
    @(negedge clk); ce_n = 0; we_n = 1; addr = 8'h52;
    repeat (3) @(negedge clk); ce_n = 1;
    repeat (BLC + PRG + 5) @(negedge clk);
    chk("R1 no program on inhibit", int'(busy_seen), 0);
    check_all("R1 array unchanged");

    // R2/R3 skewed strobes: chip enable falls last and rises first
    @(negedge clk); we_n = 0; ce_n = 1; addr = 8'h9A; din = 8'h01;
    @(negedge clk); ce_n = 0; addr = 8'h6B; din = 8'h02; t_last = cyc + 1;
    @(negedge clk); addr = 8'hC4; din = 8'hE7;
    @(negedge clk); ce_n = 1; din = 8'h55; addr = 8'h0F;
    @(negedge clk); we_n = 1;
    pg_open = 1; ppage = 5'h0D; pdat[3] = 8'hE7; pmask[3] = 1'b1;
    wait_prog(-1);
    check_all("R2 R3 skewed strobes");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule